// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Deferred Update

This block generates four independent pulse-width modulated outputs. They are set up through a small register window on an APB-style bus. Each channel holds two 32-bit settings, both counted in ticks of the bus clock. The cycle length is the number of ticks in one full waveform cycle. The high time is the number of ticks at the start of each cycle during which the output is driven high.

Bus writes land in a shadow copy of each setting. A channel that is running keeps its active copy until the cycle in progress has finished. At that boundary it takes the shadow values, so a waveform never shows a cycle made of mixed settings. A channel whose active cycle length is zero is stopped and holds its output high. Writing a non-zero cycle length to a stopped channel starts it on the next clock. Writing zero to both settings of a running channel stops it once its current cycle ends.

Each channel also drives a one-cycle strobe during the last tick of every cycle. This lets surrounding logic, or a bench, track cycle boundaries.

Top module: `pwm_bank`

## Requirements
- R1: After synchronous reset, every register reads as zero, every `pwm_out` bit is high and every `cycle_end` bit is low.
- R2: The high-time setting of channel n is at byte offset n*8 and the cycle-length setting at n*8+4. Reads of these offsets return the full 32-bit value most recently written.
- R3: A write to an offset of 0x20 or above, or to one whose two low bits are not both zero, changes no register and no output. A read of such an offset returns zero.
- R4: With cycle length P > 0 and high time H < P, the output is high for H ticks and then low for P-H ticks, repeating.
- R5: With P > 0, a high time of zero gives a constantly low output, and a high time of at least P gives a constantly high output.
- R6: A write to a running channel takes effect only at the start of the next cycle. The register reads the new value at once.
- R7: A stopped channel whose shadow cycle length becomes non-zero starts on the next clock, beginning with the high phase and without waiting for a boundary.
- R8: When the cycle length loaded at a boundary is zero, including the case where both settings are zero, the channel stops. Its output is then high and it gives no strobe.
- R9: `cycle_end` of a running channel is high for exactly the last tick of each cycle. With P = 1 that is every tick.
- R10: The channels are independent: settings written to one channel do not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and tick clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | High for write, low for read |
| paddr | input | ADDR_W | Byte offset into the register window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| pwm_out | output | NUM_CH | Waveform output per channel |
| cycle_end | output | NUM_CH | Last-tick-of-cycle strobe per channel |

## Verification
The bench targets a write that lands in the middle of a running cycle. A design that applied it at once would shorten or stretch that cycle, and the next samples would show the wrong phase. It starts channels from the stopped state and checks the very first tick is high: a design that waited for a boundary, or started with the low phase, would be off by one or more ticks. It covers the degenerate settings (H = 0, H >= P, P = 1) and the return to idle after both settings are cleared. An off-by-one in the wrap compare, or a channel left running on zero, shows up there as a wrong strobe count or a low idle output. Writes to unmapped and misaligned offsets must leave the read-back values and all four waveforms untouched.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int TICK_W = 32;
    localparam int IDX_W  = 8;

    typedef logic [TICK_W-1:0] tick_t;

    // active or shadow settings of one channel
    typedef struct packed {
        tick_t high;
        tick_t period;
    } pwm_cfg_t;

    typedef enum logic {
        FIELD_HIGH   = 1'b0,
        FIELD_PERIOD = 1'b1
    } field_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] ch;
        field_e           field;
    } reg_sel_t;

    // Byte offset -> channel / field; word-aligned offsets below nch*8 hit.
    function automatic reg_sel_t decode_addr(input logic [31:0] a, input int unsigned nch);
        reg_sel_t s;
        s.hit   = (a[1:0] == 2'b00) && ({3'b000, a[31:3]} < nch);
        s.ch    = a[IDX_W+2:3];
        s.field = a[2] ? FIELD_PERIOD : FIELD_HIGH;
        return s;
    endfunction

    function automatic logic cfg_runs(input pwm_cfg_t c);
        return c.period != '0;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [ADDR_W-1:0]        paddr,
    input  logic [TICK_W-1:0]        pwdata,
    output logic [TICK_W-1:0]        prdata,
    output pwm_cfg_t [NUM_CH-1:0]    shadow_o
);

    logic [31:0] addr_ext;
    reg_sel_t    sel;
    logic        wr_en;

    assign addr_ext = 32'(paddr);
    assign sel      = decode_addr(addr_ext, NUM_CH);
    assign wr_en    = psel && penable && pwrite;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_o[g] <= '0;
            end else if (wr_en && sel.hit && (sel.ch == IDX_W'(g))) begin
                if (sel.field == FIELD_PERIOD) shadow_o[g].period <= pwdata;
                else                           shadow_o[g].high   <= pwdata;
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && sel.hit) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (sel.ch == IDX_W'(i))
                    prdata = (sel.field == FIELD_PERIOD) ? shadow_o[i].period : shadow_o[i].high;
            end
        end
    end

    assert_unmapped_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel.hit) |=> $stable(shadow_o));

    assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (psel && !sel.hit) |-> (prdata == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwm_cfg_t shadow_i,
    output logic     pwm_o,
    output logic     wrap_o
);

    pwm_cfg_t act_q;
    tick_t    cnt_q;
    logic     run_q;
    logic     start;
    logic     load;

    assign wrap_o = run_q && (cnt_q == act_q.period - 1'b1);
    assign start  = !run_q && cfg_runs(shadow_i);
    assign load   = start || wrap_o;
    assign pwm_o  = !run_q || (cnt_q < act_q.high);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            act_q <= shadow_i;
            cnt_q <= '0;
            run_q <= cfg_runs(shadow_i);
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_wrap_restarts_R9: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_q == '0));

    assert_count_advances_R4: assert property (@(posedge clk) disable iff (rst)
        (run_q && !wrap_o) |=> (run_q && (cnt_q == $past(cnt_q) + 1'b1)));

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < act_q.period));

    assert_hold_midcycle_R6: assert property (@(posedge clk) disable iff (rst)
        (run_q && !wrap_o) |=> $stable(act_q));

    assert_load_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (act_q == $past(shadow_i)));

    assert_start_next_clock_R7: assert property (@(posedge clk) disable iff (rst)
        (!run_q && (shadow_i.period != '0)) |=> (run_q && (cnt_q == '0)));

    assert_stop_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && (shadow_i.period == '0)) |=> (pwm_o && !wrap_o));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] cycle_end
);

    pwm_cfg_t [NUM_CH-1:0] shadow;

    pwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .shadow_o (shadow)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .shadow_i (shadow[g]),
            .pwm_o    (pwm_out[g]),
            .wrap_o   (cycle_end[g])
        );
    end

    assert_reset_outputs_R1: assert property (@(posedge clk)
        rst |=> (&pwm_out && (cycle_end == '0)));

endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  pwm_out, cycle_end;

    always #2.5 clk = ~clk;

    pwm_bank u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pwm_out(pwm_out), .cycle_end(cycle_end)
    );

    typedef struct {
        logic [3:0] out;
        logic [3:0] stb;
        string      tag;
    } exp_t;

    exp_t  sb[$];
    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // expected state, from the requirements
    logic [31:0] m_sh_hi[4], m_sh_per[4], m_hi[4], m_per[4], m_cnt[4];
    bit          m_run[4];

    task automatic tick();
        exp_t e;
        if (rst) begin
            for (int c = 0; c < 4; c++) begin
                m_sh_hi[c] = 0; m_sh_per[c] = 0; m_hi[c] = 0; m_per[c] = 0;
                m_cnt[c] = 0; m_run[c] = 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                if ((!m_run[c] && m_sh_per[c] != 0) || (m_run[c] && m_cnt[c] == m_per[c] - 1)) begin
                    m_hi[c] = m_sh_hi[c]; m_per[c] = m_sh_per[c];
                    m_cnt[c] = 0; m_run[c] = (m_sh_per[c] != 0);
                end else if (m_run[c]) begin
                    m_cnt[c] = m_cnt[c] + 1;
                end
            end
            if (psel && penable && pwrite && paddr[1:0] == 2'b00 && paddr < 6'h20) begin
                if (paddr[2]) m_sh_per[paddr[4:3]] = pwdata;
                else          m_sh_hi[paddr[4:3]]  = pwdata;
            end
        end
        for (int c = 0; c < 4; c++) begin
            e.out[c] = !m_run[c] || (m_cnt[c] < m_hi[c]);
            e.stb[c] = m_run[c] && (m_cnt[c] == m_per[c] - 1);
        end
        e.tag = cur_tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: one expected item per clock edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            compared++;
            if (pwm_out !== e.out || cycle_end !== e.stb) begin
                mismatched++;
                $display("FAIL %s: pwm_out=%b cycle_end=%b expected pwm_out=%b cycle_end=%b at %0t",
                         e.tag, pwm_out, cycle_end, e.out, e.stb, $time);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        tick();
        penable = 1'b1;
        tick();
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp_v, input string tag);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        tick();
        penable = 1'b1;
        #1;
        compared++;
        if (prdata !== exp_v) begin
            mismatched++;
            $display("FAIL %s: read 0x%0h got 0x%08h expected 0x%08h", tag, a, prdata, exp_v);
        end
        tick();
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        do_reset();
        for (int i = 0; i < 8; i++) rd(6'(i * 4), 32'h0, "R1");
        idle(3);

        // R4 R7 R9 R2: start ch0 from idle with H=2 P=5
        cur_tag = "R7";
        wr(6'h00, 32'd2);
        cur_tag = "R4";
        wr(6'h04, 32'd5);
        idle(14);
        rd(6'h00, 32'd2, "R2");
        rd(6'h04, 32'd5, "R2");
        cur_tag = "R9";
        idle(6);

        // R5 R10: degenerate settings on the other channels
        do_reset();
        cur_tag = "R5";
        wr(6'h0C, 32'd3);          // ch1 P=3, H=0 -> low
        wr(6'h10, 32'd7);          // ch2 H=7
        wr(6'h14, 32'd4);          // ch2 P=4 -> high
        wr(6'h18, 32'd1);          // ch3 H=1
        wr(6'h1C, 32'd1);          // ch3 P=1 -> high, strobe each tick
        cur_tag = "R10";
        idle(12);
        wr(6'h08, 32'd2);          // ch1 H=2 at next boundary
        idle(10);

        // R6: mid-cycle update of a running channel
        do_reset();
        cur_tag = "R6";
        wr(6'h00, 32'd1);
        wr(6'h04, 32'd6);
        idle(2);
        wr(6'h00, 32'd4);
        wr(6'h04, 32'd4);
        rd(6'h00, 32'd4, "R6");
        rd(6'h04, 32'd4, "R6");
        idle(16);

        // R8: clearing both settings stops the channel at the boundary
        cur_tag = "R8";
        wr(6'h04, 32'd0);
        wr(6'h00, 32'd0);
        idle(12);
        rd(6'h04, 32'd0, "R8");

        // R2: full-width read-back
        cur_tag = "R2";
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, 32'hFFFF_FFFF, "R2");
        idle(4);

        // R3: unmapped and misaligned accesses
        do_reset();
        cur_tag = "R3";
        wr(6'h08, 32'd1);
        wr(6'h0C, 32'd3);
        idle(2);
        wr(6'h20, 32'd9);
        wr(6'h0D, 32'd9);
        wr(6'h3C, 32'd9);
        idle(6);
        rd(6'h20, 32'h0, "R3");
        rd(6'h0D, 32'h0, "R3");
        rd(6'h0C, 32'd3, "R3");
        rd(6'h08, 32'd1, "R3");
        rd(6'h04, 32'd0, "R3");
        idle(6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule